// File: doc/BRIEF.md
# Dual PWM Switching-Regulator Driver

This block generates two independent pulse-width-modulated drive signals for switching regulators. Each channel holds two configuration banks, each a 3-bit frequency code and a 4-bit duty code. A per-channel select pin chooses which bank is live, so the drive can be moved between two operating points with no register traffic. Settings move into a channel only at the end of its current PWM period. Mid-period changes therefore never truncate or stretch a pulse.

Each PWM period has sixteen phase steps. With frequency code n, one phase step lasts 2^(n+1) input clocks, so the period is 16·2^(n+1) clocks. The output is active during the first d steps of the period, where d is the duty code, so code 0 never drives. Each channel has a regulation-met input that suppresses the drive for the rest of the current period. This gives closed-loop skip behaviour. The active level of each output is set by a polarity pin that is sampled while reset is held and kept unchanged afterwards.

The configuration port is a plain single-cycle write strobe. The block carries no data stream, so it has no valid/ready handshake and never applies back-pressure. A write is accepted in the cycle `wr_en` is high.

Top module: `pwm_pair_driver`

## Requirements
- R1: While `rst_n` is low, and after its release, each output sits at its inactive level. All four banks are cleared to frequency code 0 and duty code 0. Each channel starts a first period of 32 clocks, using code 0 settings, before it loads a bank.
- R2: Each output bit equals its channel's internal active state XOR the polarity captured from `pol_sel` on clock edges while `rst_n` is low. Bit value 1 makes the output active-low. The captured value does not change while `rst_n` is high.
- R3: A rising clock edge with `wr_en` high stores `wr_freq` and `wr_duty` into the bank of channel `wr_ch` named by `wr_bank` (0 or 1).
- R4: With frequency code n, the phase advances every 2^(n+1) clocks and the PWM period is 16·2^(n+1) clocks.
- R5: With duty code d in 1..15, the output is active for the first d·2^(n+1) clocks of each period and inactive for the rest.
- R6: Duty code 0 keeps the output at its inactive level for the whole period, with no pulse.
- R7: `bank_sel[c]` = 0 selects bank 0 of channel c, and 1 selects bank 1.
- R8: A bank write or a change of `bank_sel` has no effect on the period in progress. The new setting applies from the next period boundary.
- R9: When `reg_met[c]` is high at a clock edge, output c is inactive from the next cycle until the end of the current period. The next period drives again only if `reg_met[c]` is low at the boundary edge.
- R10: The two channels are independent. Settings, select and regulation-met input of one channel never change the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; also the base of all PWM timing |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| pol_sel | input | 2 | Per-channel polarity, captured while reset is low (1 = active-low) |
| wr_en | input | 1 | Configuration write strobe |
| wr_ch | input | 1 | Channel addressed by the write |
| wr_bank | input | 1 | Bank addressed by the write |
| wr_freq | input | 3 | Frequency code n |
| wr_duty | input | 4 | Duty code in sixteenths |
| bank_sel | input | 2 | Live bank selection per channel |
| reg_met | input | 2 | Per-channel regulation-met feedback |
| pwm_out | output | 2 | PWM drive outputs |

## Verification
A wrong prescaler or phase count shows as a wrong output period. It becomes visible at the first rising edge of the active level, at most one period (up to 4096 clocks) later. A wrong live setting or a missed boundary load shows as a wrong active-cycle count within a single period. A boundary load taken too early shows in the very period in which a write or select change lands, because that period's pulse width changes. Feedback state that is not cleared or set correctly appears one cycle after `reg_met` rises, or as a missing pulse in the following period. Lost polarity appears as an inverted idle level on the first cycle after reset.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int FREQ_W = 3;
  localparam int DUTY_W = 4;
  localparam int PRE_W  = 1 << FREQ_W;

  typedef struct packed {
    logic [FREQ_W-1:0] freq;
    logic [DUTY_W-1:0] duty;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_cfg_bank.sv
module pwm_cfg_bank
  import pwm_pair_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [CH_W-1:0]        wr_ch,
  input  logic                   wr_bank,
  input  pwm_cfg_t               wr_cfg,
  output pwm_cfg_t [NUM_CH-1:0]  cfg_b0,
  output pwm_cfg_t [NUM_CH-1:0]  cfg_b1
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_b0[c] <= '0;
        cfg_b1[c] <= '0;
      end else if (wr_en && (wr_ch == CH_W'(c))) begin
        if (wr_bank) cfg_b1[c] <= wr_cfg;
        else         cfg_b0[c] <= wr_cfg;
      end
    end
  end
endmodule

// File: rtl/pwm_pol_latch.sv
module pwm_pol_latch #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pol_sel,
  output logic [NUM_CH-1:0] pol_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) pol_q <= pol_sel;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  pwm_cfg_t          cfg_b0,
  input  pwm_cfg_t          cfg_b1,
  input  logic              bank_sel,
  input  logic              reg_met,
  input  logic              pol,
  output logic              pwm_o,
  output logic              wrap_o,
  output logic [DUTY_W-1:0] duty_o
);
  pwm_cfg_t          act_q;
  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  lim;
  logic [FREQ_W-1:0] shamt;
  logic [DUTY_W-1:0] phase_q;
  logic              hold_q;
  logic              tick;
  logic              wrap;

  // step length 2^(n+1) clocks: terminal count is 2^(n+1)-1
  always_comb begin
    shamt = FREQ_W'(PRE_W - 1) - act_q.freq;
    lim   = {PRE_W{1'b1}} >> shamt;
    tick  = (pre_q == lim);
    wrap  = tick && (phase_q == {DUTY_W{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= '0;
      pre_q   <= '0;
      phase_q <= '0;
      hold_q  <= 1'b0;
    end else begin
      pre_q  <= tick ? '0 : pre_q + 1'b1;
      hold_q <= wrap ? reg_met : (hold_q | reg_met);
      if (tick) phase_q <= phase_q + 1'b1;
      if (wrap) act_q <= bank_sel ? cfg_b1 : cfg_b0;
    end
  end

  assign pwm_o  = pol ^ ((phase_q < act_q.duty) && !hold_q);
  assign wrap_o = wrap;
  assign duty_o = act_q.duty;
endmodule

// File: rtl/pwm_pair_driver.sv
module pwm_pair_driver
  import pwm_pair_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pol_sel,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic              wr_bank,
  input  logic [FREQ_W-1:0] wr_freq,
  input  logic [DUTY_W-1:0] wr_duty,
  input  logic [NUM_CH-1:0] bank_sel,
  input  logic [NUM_CH-1:0] reg_met,
  output logic [NUM_CH-1:0] pwm_out
);
  pwm_cfg_t [NUM_CH-1:0]              cfg_b0;
  pwm_cfg_t [NUM_CH-1:0]              cfg_b1;
  pwm_cfg_t                           wr_cfg;
  logic     [NUM_CH-1:0]              pol_q;
  logic     [NUM_CH-1:0]              wrap;
  logic     [NUM_CH-1:0][DUTY_W-1:0]  duty_act;

  assign wr_cfg = '{freq: wr_freq, duty: wr_duty};

  pwm_cfg_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_bank(wr_bank), .wr_cfg(wr_cfg), .cfg_b0(cfg_b0), .cfg_b1(cfg_b1)
  );

  pwm_pol_latch #(.NUM_CH(NUM_CH)) u_pol (
    .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .pol_q(pol_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_chan u_chan (
      .clk(clk), .rst_n(rst_n), .cfg_b0(cfg_b0[c]), .cfg_b1(cfg_b1[c]),
      .bank_sel(bank_sel[c]), .reg_met(reg_met[c]), .pol(pol_q[c]),
      .pwm_o(pwm_out[c]), .wrap_o(wrap[c]), .duty_o(duty_act[c])
    );
  end
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk
  import pwm_pair_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_CH-1:0]              pol_q,
  input logic [NUM_CH-1:0]              reg_met,
  input logic [NUM_CH-1:0]              pwm_out,
  input logic [NUM_CH-1:0]              wrap,
  input logic [NUM_CH-1:0][DUTY_W-1:0]  duty_act
);
  // R2
  pol_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(pol_q));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R6
    duty_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_act[c] == '0) |-> (pwm_out[c] == pol_q[c]));
    // R9
    met_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_met[c] |=> (pwm_out[c] == pol_q[c]));
    // R8
    cfg_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap[c] |=> $stable(duty_act[c]));
  end
endmodule

bind pwm_pair_driver pwm_pair_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pol_q(pol_q), .reg_met(reg_met),
  .pwm_out(pwm_out), .wrap(wrap), .duty_act(duty_act)
);

// File: tb/test_pwm_pair_driver.sv
module test_pwm_pair_driver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pol_sel = 2'b00;
  logic       wr_en = 1'b0;
  logic       wr_ch = 1'b0;
  logic       wr_bank = 1'b0;
  logic [2:0] wr_freq = '0;
  logic [3:0] wr_duty = '0;
  logic [1:0] bank_sel = 2'b00;
  logic [1:0] reg_met = 2'b00;
  logic [1:0] pwm_out;
  logic [1:0] pol_cur = 2'b00;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pwm_pair_driver i_pwm_pair_driver (
    .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_bank(wr_bank), .wr_freq(wr_freq), .wr_duty(wr_duty),
    .bank_sel(bank_sel), .reg_met(reg_met), .pwm_out(pwm_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic active(input int ch);
    return pwm_out[ch] ^ pol_cur[ch];
  endfunction

  task automatic do_reset(input logic [1:0] pol);
    @(negedge clk);
    rst_n = 1'b0; pol_sel = pol; pol_cur = pol;
    bank_sel = 2'b00; reg_met = 2'b00; wr_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    pol_sel = ~pol;
  endtask

  task automatic write_cfg(input logic ch, input logic bank, input int f, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = ch; wr_bank = bank; wr_freq = 3'(f); wr_duty = 4'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_act(input int ch, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (active(ch)) cnt++;
    end
  endtask

  task automatic wait_rise(input int ch);
    logic prev;
    prev = active(ch);
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (active(ch) && !prev) return;
      prev = active(ch);
    end
  endtask

  task automatic period_of(input int ch, output int len);
    wait_rise(ch);
    len = 0;
    begin
      logic prev;
      prev = 1'b1;
      for (int i = 0; i < 10000; i++) begin
        @(negedge clk);
        len++;
        if (active(ch) && !prev) break;
        prev = active(ch);
      end
    end
  endtask

  task automatic t_reset();
    int c0, c1;
    do_reset(2'b10);
    check("R1 R2 idle level after reset", int'(pwm_out), 2);
    count_act(0, 200, c0);
    check("R1 ch0 no drive from cleared banks", c0, 0);
    count_act(1, 50, c1);
    check("R1 ch1 no drive from cleared banks", c1, 0);
  endtask

  task automatic t_freq_duty();
    int c, p;
    do_reset(2'b00);
    write_cfg(0, 0, 0, 4);
    repeat (100) @(negedge clk);
    count_act(0, 128, c);
    check("R3 R5 n0 d4 active count", c, 32);
    period_of(0, p);
    check("R4 n0 period", p, 32);
    write_cfg(0, 0, 2, 8);
    repeat (300) @(negedge clk);
    count_act(0, 512, c);
    check("R5 n2 d8 active count", c, 256);
    period_of(0, p);
    check("R4 n2 period", p, 128);
    write_cfg(0, 0, 7, 1);
    repeat (9000) @(negedge clk);
    period_of(0, p);
    check("R4 n7 period", p, 4096);
  endtask

  task automatic t_duty_edges();
    int c;
    do_reset(2'b00);
    write_cfg(0, 0, 0, 15);
    repeat (100) @(negedge clk);
    count_act(0, 512, c);
    check("R5 d15 active count", c, 480);
    write_cfg(0, 0, 0, 0);
    repeat (100) @(negedge clk);
    count_act(0, 256, c);
    check("R6 d0 never active", c, 0);
  endtask

  task automatic t_bank();
    int c, p;
    do_reset(2'b00);
    write_cfg(0, 0, 0, 4);
    write_cfg(0, 1, 1, 12);
    repeat (100) @(negedge clk);
    count_act(0, 128, c);
    check("R7 bank0 selected count", c, 32);
    @(negedge clk); bank_sel[0] = 1'b1;
    repeat (200) @(negedge clk);
    count_act(0, 256, c);
    check("R3 R7 bank1 selected count", c, 192);
    period_of(0, p);
    check("R7 bank1 period", p, 64);
  endtask

  task automatic t_defer();
    int c;
    do_reset(2'b00);
    write_cfg(0, 0, 0, 4);
    repeat (100) @(negedge clk);
    wait_rise(0);
    c = 0;
    for (int i = 0; i < 30; i++) begin
      if (active(0)) c++;
      if (i == 1) begin wr_en = 1'b1; wr_ch = 1'b0; wr_bank = 1'b0; wr_freq = 3'd0; wr_duty = 4'd12; end
      if (i == 2) wr_en = 1'b0;
      @(negedge clk);
    end
    check("R8 write mid-period keeps old width", c, 8);
    wait_rise(0);
    count_act(0, 30, c);
    check("R8 write applies next period", c + 1, 24);
    write_cfg(0, 1, 0, 2);
    wait_rise(0);
    c = 0;
    for (int i = 0; i < 30; i++) begin
      if (active(0)) c++;
      if (i == 1) bank_sel[0] = 1'b1;
      @(negedge clk);
    end
    check("R8 select mid-period keeps old width", c, 24);
    wait_rise(0);
    count_act(0, 30, c);
    check("R8 select applies next period", c + 1, 4);
  endtask

  task automatic t_feedback();
    int c;
    do_reset(2'b00);
    write_cfg(0, 0, 0, 8);
    repeat (100) @(negedge clk);
    wait_rise(0);
    c = 0;
    for (int i = 0; i < 30; i++) begin
      if (active(0)) c++;
      if (i == 2) reg_met[0] = 1'b1;
      if (i == 3) reg_met[0] = 1'b0;
      @(negedge clk);
    end
    check("R9 pulse blanks rest of period", c, 3);
    wait_rise(0);
    count_act(0, 30, c);
    check("R9 next period drives again", c + 1, 16);
    @(negedge clk); reg_met[0] = 1'b1;
    count_act(0, 128, c);
    check("R9 held feedback suppresses drive", c, 0);
    reg_met[0] = 1'b0;
    repeat (40) @(negedge clk);
    count_act(0, 128, c);
    check("R9 release restores drive", c, 64);
  endtask

  task automatic t_polarity();
    int c;
    do_reset(2'b11);
    check("R2 active-low idle", int'(pwm_out), 3);
    write_cfg(0, 0, 0, 4);
    repeat (100) @(negedge clk);
    c = 0;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      if (pwm_out[0] == 1'b0) c++;
    end
    check("R2 low cycles with active-low output", c, 32);
    check("R2 ch1 stays high", int'(pwm_out[1]), 1);
  endtask

  task automatic t_indep();
    int c0, c1;
    do_reset(2'b00);
    write_cfg(0, 0, 0, 4);
    write_cfg(1, 0, 1, 10);
    repeat (200) @(negedge clk);
    count_act(0, 256, c0);
    check("R10 ch0 unaffected by ch1", c0, 32 * 2);
    count_act(1, 256, c1);
    check("R10 ch1 own setting", c1, 160);
    @(negedge clk); reg_met[1] = 1'b1; bank_sel[1] = 1'b1;
    count_act(0, 256, c0);
    check("R10 ch0 ignores ch1 feedback and select", c0, 64);
    reg_met[1] = 1'b0;
  endtask

  initial begin
    t_reset();
    t_freq_duty();
    t_duty_edges();
    t_bank();
    t_defer();
    t_feedback();
    t_polarity();
    t_indep();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule